// File: doc/BRIEF.md
# Power Management Control and Status Register

This block holds the 16-bit power management control and status word of a PCI function. Configuration software reads the whole word on `rd_data` and writes it through a one-cycle write strobe. The word carries a wake status flag, cleared by writing one, and a wake enable bit. Their AND drives the active-low wake pin. It also carries a four-bit data selector, a two-bit power state and a read-only scale field taken from the data logic.

The status, enable and selector fields survive every reset except power-on. The hard reset case differs by configuration. If the function cannot raise wake events from the unpowered state, a hard reset must also clear status and enable. The capability bit that decides this comes from the serial configuration load that follows the hard reset, so the clear is held pending and applied on the load-done strobe. The clear is applied when the loaded capability bit is zero or the auxiliary supply sense is low. The capability bit is latched on every load-done strobe and is reported ANDed with the supply sense.

Top module: `pm_ctl_stat`

## Requirements
- R1: While `por_n` is low every stored field is cleared and the latched capability bit is zero. `rd_data` then shows only the scale input in bits 14:13, `pme_n` is 1 and `d3c_ok` is 0.
- R2: `wake_evt` high at a clock edge sets the status bit (`rd_data[15]`) at that edge, whatever the enable bit holds.
- R3: A write with `wr_data[15]`=1 clears the status bit. A write with `wr_data[15]`=0 leaves it unchanged.
- R4: When `wake_evt` and a write with `wr_data[15]`=1 occur in the same cycle, the status bit is 1 afterwards.
- R5: `pme_n` is 0 exactly when the status bit and the enable bit (`rd_data[8]`) are both 1.
- R6: A write loads the enable bit from `wr_data[8]`, the selector (`rd_data[12:9]`) from `wr_data[12:9]` and the power state (`rd_data[1:0]`) from `wr_data[1:0]`. Bits 14:13 always read `data_scale`, and bits 7:2 read zero whatever is written.
- R7: A `hard_rst` cycle clears the power state, even if a write occurs in the same cycle. It leaves the selector, status and enable bits unchanged at that edge.
- R8: The first `load_done` after a `hard_rst` clears status and enable when `load_d3c`=0 or `vaux_ok`=0 in that cycle. The selector is kept.
- R9: The first `load_done` after a `hard_rst` leaves status and enable unchanged when `load_d3c`=1 and `vaux_ok`=1.
- R10: A `load_done` with no `hard_rst` since the previous `load_done` (or since power-on) clears nothing.
- R11: Each `load_done` latches `load_d3c`. `d3c_ok` is the latched bit ANDed with the current `vaux_ok`.
- R12: A deferred clear overrides a wake event and a write in the same cycle: status and enable end up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hard_rst | input | 1 | Hard reset pulse, synchronous |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 16 | Write data |
| wake_evt | input | 1 | Wake event from the function |
| load_done | input | 1 | End of configuration load strobe |
| load_d3c | input | 1 | Loaded capability bit for wake from the unpowered state |
| vaux_ok | input | 1 | Auxiliary supply present |
| data_scale | input | 2 | Scale value from the data logic |
| rd_data | output | 16 | Current register word |
| pme_n | output | 1 | Wake pin, active low |
| pwr_state | output | 2 | Requested power state |
| d3c_ok | output | 1 | Wake from the unpowered state supported |

## Verification
The deferred clear is the hardest case to reach. It needs a hard reset, then an arbitrary gap, then a load strobe whose capability data and supply sense pick the outcome. The same flags must be set beforehand, or nothing can be observed. The stimulus sets status and enable, pulses a hard reset and idles so the flags are seen to survive. It then ends the load with each support combination, including one where a wake event and a write land on the load strobe. A second load strobe with no hard reset before it shows that the pending state was consumed.

// File: rtl/pm_ctl_pkg.sv
package pm_ctl_pkg;
    localparam int REG_W    = 16;
    localparam int STAT_BIT = 15;
    localparam int SCALE_LO = 13;
    localparam int SCALE_W  = 2;
    localparam int SEL_LO   = 9;
    localparam int SEL_W    = 4;
    localparam int EN_BIT   = 8;
    localparam int PWR_LO   = 0;
    localparam int PWR_W    = 2;
    localparam int RSV_LO   = PWR_LO + PWR_W;
    localparam int RSV_W    = EN_BIT - RSV_LO;

    typedef struct packed {
        logic             stat;
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [PWR_W-1:0] pwr;
    } pm_fields_t;

    typedef struct packed {
        logic pend;
        logic sup;
    } pm_defer_t;
endpackage

// File: rtl/pm_defer_clr.sv
module pm_defer_clr
    import pm_ctl_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic hard_rst,
    input  logic load_done,
    input  logic load_d3c,
    input  logic vaux_ok,
    output logic clr_now,
    output logic d3c_ok
);
    pm_defer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_done) begin
            st_d.sup  = load_d3c;
            st_d.pend = 1'b0;
        end
        if (hard_rst) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_now = load_done & st_q.pend & ~(load_d3c & vaux_ok);
    assign d3c_ok  = st_q.sup & vaux_ok;

    p_latch_sup_r11: assert property (@(posedge clk) disable iff (!por_n)
        load_done |=> (st_q.sup == $past(load_d3c)));
    p_pend_set_r8: assert property (@(posedge clk) disable iff (!por_n)
        hard_rst |=> st_q.pend);
    p_pend_gone_r10: assert property (@(posedge clk) disable iff (!por_n)
        (load_done && !hard_rst) |=> !st_q.pend);
endmodule

// File: rtl/pm_field_regs.sv
module pm_field_regs
    import pm_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wake,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hard_rst,
    input  logic             clr_now,
    output pm_fields_t       fld_q
);
    pm_fields_t fld_d;

    always_comb begin
        fld_d = fld_q;
        if (wr_en) begin
            fld_d.en  = wr_data[EN_BIT];
            fld_d.sel = wr_data[SEL_LO +: SEL_W];
            fld_d.pwr = wr_data[PWR_LO +: PWR_W];
            if (wr_data[STAT_BIT]) fld_d.stat = 1'b0;
        end
        if (wake)     fld_d.stat = 1'b1;
        if (hard_rst) fld_d.pwr  = '0;
        if (clr_now) begin
            fld_d.stat = 1'b0;
            fld_d.en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end

    p_wake_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
        (wake && !clr_now) |=> fld_q.stat);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_data[STAT_BIT] && !wake && !clr_now) |=> !fld_q.stat);
    p_w0_keep_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!(wr_en && wr_data[STAT_BIT]) && !wake && !clr_now) |=> $stable(fld_q.stat));
    p_hr_pwr_r7: assert property (@(posedge clk) disable iff (!por_n)
        hard_rst |=> (fld_q.pwr == '0));
    p_hr_sel_r7: assert property (@(posedge clk) disable iff (!por_n)
        (hard_rst && !wr_en) |=> $stable(fld_q.sel));
    p_clr_wins_r12: assert property (@(posedge clk) disable iff (!por_n)
        clr_now |=> (!fld_q.stat && !fld_q.en));
endmodule

// File: rtl/pm_ctl_stat.sv
module pm_ctl_stat
    import pm_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                por_n,
    input  logic                hard_rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                wake_evt,
    input  logic                load_done,
    input  logic                load_d3c,
    input  logic                vaux_ok,
    input  logic [SCALE_W-1:0]  data_scale,
    output logic [REG_W-1:0]    rd_data,
    output logic                pme_n,
    output logic [PWR_W-1:0]    pwr_state,
    output logic                d3c_ok
);
    logic       clr_now;
    pm_fields_t fld_q;

    pm_defer_clr u_defer (
        .clk       (clk),
        .por_n     (por_n),
        .hard_rst  (hard_rst),
        .load_done (load_done),
        .load_d3c  (load_d3c),
        .vaux_ok   (vaux_ok),
        .clr_now   (clr_now),
        .d3c_ok    (d3c_ok)
    );

    pm_field_regs u_fields (
        .clk      (clk),
        .por_n    (por_n),
        .wake     (wake_evt),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .hard_rst (hard_rst),
        .clr_now  (clr_now),
        .fld_q    (fld_q)
    );

    always_comb begin
        rd_data                          = '0;
        rd_data[STAT_BIT]                = fld_q.stat;
        rd_data[SCALE_LO +: SCALE_W]     = data_scale;
        rd_data[SEL_LO +: SEL_W]         = fld_q.sel;
        rd_data[EN_BIT]                  = fld_q.en;
        rd_data[PWR_LO +: PWR_W]         = fld_q.pwr;
    end

    assign pme_n     = ~(fld_q.stat & fld_q.en);
    assign pwr_state = fld_q.pwr;

    p_en_follows_r6: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !load_done) |=> (rd_data[EN_BIT] == $past(wr_data[EN_BIT])));
    p_pin_idle_r5: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_en && !load_done) |=> (pme_n || $past(!pme_n) || $past(wake_evt)));
endmodule

// File: tb/pm_ctl_stat_test.sv
module pm_ctl_stat_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        hard_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wake_evt = 1'b0;
    logic        load_done = 1'b0;
    logic        load_d3c = 1'b0;
    logic        vaux_ok = 1'b1;
    logic [1:0]  data_scale = 2'b10;
    logic [15:0] rd_data;
    logic        pme_n;
    logic [1:0]  pwr_state;
    logic        d3c_ok;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // independent model state
    logic       m_stat = 0, m_en = 0, m_pend = 0, m_sup = 0;
    logic [3:0] m_sel = 0;
    logic [1:0] m_pwr = 0;

    logic [15:0] q_rd[$];
    logic        q_pme[$];
    logic        q_sup[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_ctl_stat uut (
        .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .wr_en(wr_en),
        .wr_data(wr_data), .wake_evt(wake_evt), .load_done(load_done),
        .load_d3c(load_d3c), .vaux_ok(vaux_ok), .data_scale(data_scale),
        .rd_data(rd_data), .pme_n(pme_n), .pwr_state(pwr_state), .d3c_ok(d3c_ok)
    );

    function automatic logic [15:0] model_word();
        return {m_stat, data_scale, m_sel, m_en, 6'b0, m_pwr};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic wk, input logic we, input logic [15:0] wd,
                        input logic hr, input logic ld, input logic lb,
                        input logic va, input string tag);
        logic dc;
        @(negedge clk);
        wake_evt = wk; wr_en = we; wr_data = wd; hard_rst = hr;
        load_done = ld; load_d3c = lb; vaux_ok = va;
        dc = ld & m_pend & ~(lb & va);
        if (we) begin
            m_en = wd[8]; m_sel = wd[12:9]; m_pwr = wd[1:0];
            if (wd[15]) m_stat = 0;
        end
        if (wk) m_stat = 1;
        if (hr) m_pwr = 0;
        if (dc) begin m_stat = 0; m_en = 0; end
        if (ld) begin m_sup = lb; m_pend = 0; end
        if (hr) m_pend = 1;
        q_rd.push_back(model_word());
        q_pme.push_back(~(m_stat & m_en));
        q_sup.push_back(m_sup & va);
        q_tag.push_back(tag);
        @(posedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 16'h0, 0, 0, load_d3c, vaux_ok, tag);
    endtask

    // monitor: compares design outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_rd.size() != 0) begin
                string t;
                t = q_tag.pop_front();
                check(t, "rd_data", rd_data, q_rd.pop_front());
                check(t, "pme_n", {15'b0, pme_n}, {15'b0, q_pme.pop_front()});
                check(t, "d3c_ok", {15'b0, d3c_ok}, {15'b0, q_sup.pop_front()});
            end
        end
    end

    task automatic reset_check(input string tag);
        #1;
        check(tag, "rd_data in reset", rd_data, 16'h4000);
        check(tag, "pme_n in reset", {15'b0, pme_n}, 16'h1);
        check(tag, "d3c_ok in reset", {15'b0, d3c_ok}, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: power-on reset state
        repeat (2) @(negedge clk);
        reset_check("R1");
        @(negedge clk);
        por_n = 1'b1;

        step(1, 0, 16'h0000, 0, 0, 0, 1, "R2 wake with enable off");
        step(0, 1, 16'h0100, 0, 0, 0, 1, "R3 R5 write0 keeps status, enable on");
        step(0, 1, 16'h8100, 0, 0, 0, 1, "R3 R5 write1 clears status");
        step(1, 1, 16'h8100, 0, 0, 0, 1, "R4 wake beats write1");
        step(0, 1, 16'h61FF | 16'h1400, 0, 0, 0, 1, "R6 fields, reserved and scale ignored");
        step(0, 1, 16'h1503, 0, 0, 0, 1, "R6 selector and power state");
        step(0, 0, 16'h0, 1, 0, 0, 1, "R7 hard reset clears power state only");
        idle("R7 status and enable held while load pending");
        idle("R7 held");
        step(0, 0, 16'h0, 0, 1, 0, 1, "R8 load without capability clears");
        step(1, 1, 16'h0102, 0, 0, 0, 1, "R2 set again");
        step(0, 0, 16'h0, 0, 1, 0, 1, "R10 load with no hard reset clears nothing");
        step(0, 0, 16'h0, 1, 0, 0, 1, "R7 second hard reset");
        step(0, 0, 16'h0, 0, 1, 1, 1, "R9 R11 supported load keeps flags");
        step(0, 0, 16'h0, 0, 0, 1, 0, "R11 supply sense low");
        step(0, 0, 16'h0, 0, 0, 1, 1, "R11 supply sense back");
        step(0, 1, 16'h0103, 1, 0, 1, 1, "R7 hard reset beats write on power state");
        step(1, 1, 16'h0100, 0, 1, 1, 0, "R8 R12 clear beats wake and write");
        step(1, 1, 16'h0100, 0, 0, 1, 1, "R5 pin asserted");
        step(0, 0, 16'h0, 1, 0, 1, 1, "R7 hard reset");
        step(0, 0, 16'h0, 0, 1, 0, 0, "R8 capability and supply both absent");
        idle("R8 stays cleared");

        // R1 again mid-run
        @(negedge clk);
        por_n = 1'b0;
        m_stat = 0; m_en = 0; m_sel = 0; m_pwr = 0; m_pend = 0; m_sup = 0;
        reset_check("R1 R11 repeat reset");
        @(negedge clk);
        por_n = 1'b1;
        step(0, 0, 16'h0, 0, 1, 0, 1, "R10 load after power-on clears nothing");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule